// File: doc/BRIEF.md
# Command and Interrupt-Status Port Unit

This unit is the host's control port on a network controller. The host writes 16-bit command words into it and reads a 16-bit status word back from the same place. Each command word has a 5-bit opcode in bits 15-11 and an 11-bit argument in bits 10-0. The unit decodes the opcode, keeps the register-window number the host has selected, and latches event flags that the rest of the controller raises. It lets the host clear those flags one at a time, masks them into a single interrupt output, and hides chosen flags from the status word.

The unit drives enable levels and one-cycle reset pulses to the receive, transmit and statistics blocks. After any reset-type command it raises a busy flag for a set number of cycles. While the flag is high it refuses new commands, so the host polls status bit 12 before it issues the next word.

Top module: `cmd_status_unit`

## Requirements
- R1: After reset, `status` reads 0, and `irq`, `busy`, `rx_on`, `tx_on`, `stats_on` and all three pulse outputs are 0. The receiver is therefore off at power-up.
- R2: Opcode 1 loads the window number from argument bits 2-0. Argument bits 10-3 are ignored. The window number is reported in `status[15:13]`.
- R3: Opcode 13 is the acknowledge command. Each set argument bit in positions 7-1 clears the event latched at the same status position. Argument bit 0 has no effect.
- R4: Opcode 14 loads the interrupt mask from argument bits 7-0. Mask bit 0 is unused. `irq` is high when some latched event in bits 7-1 has its mask bit set, and status bit 0 shows that same condition.
- R5: Opcode 15 loads the read-zero mask from argument bits 7-0. A status bit in positions 7-0 whose mask bit is 0 reads as 0, but the event stays latched and shows again once its mask bit is set.
- R6: Each set bit of `ev_set` in positions 1-5 and 7 latches the event at the same status bit position. Opcode 12 latches bit 6. Bits 6 and 0 of `ev_set` have no effect.
- R7: Opcode 4 sets `rx_on` and opcode 3 clears it. Opcodes 9 and 10 do the same for `tx_on`, and opcodes 21 and 22 for `stats_on`. `status[12]` equals `busy`, and `status[11:8]` always reads 0.
- R8: Opcodes 0, 5 and 11 raise `busy` for BUSY_CYC cycles, starting in the cycle after the command is accepted. A command written while `busy` is high is ignored.
- R9: Opcode 0 clears the window, the events, both masks and the three enable levels. Opcode 5 clears `rx_on` and opcode 11 clears `tx_on`. Opcodes 0, 5 and 11 each produce a one-cycle pulse on `gbl_rst_p`, `rx_rst_p` and `tx_rst_p` respectively.
- R10: When an `ev_set` bit and an acknowledge of the same bit arrive in the same cycle, the event stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode in bits 15-11, argument in bits 10-0 |
| ev_set | input | 8 | Event raise pulses, one per status bit position |
| status | output | 16 | Status word: window, busy, reserved zeros, masked events |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Command in progress |
| win | output | 3 | Selected register window |
| rx_on | output | 1 | Receiver enabled |
| tx_on | output | 1 | Transmitter enabled |
| stats_on | output | 1 | Statistics enabled |
| rx_rst_p | output | 1 | Receiver reset pulse |
| tx_rst_p | output | 1 | Transmitter reset pulse |
| gbl_rst_p | output | 1 | Global reset pulse |

## Verification
The assertions check the following on every cycle:
- a write while busy leaves the window unchanged;
- an accepted reset opcode raises busy;
- an acknowledge clears the named events unless they are raised again in the same cycle;
- opcode 12 latches bit 6;
- an interrupt never occurs with an all-zero mask;
- the three reset pulses never overlap.

Only the bench scenarios can show the rest:
- the exact length of the busy window;
- events hidden by the read-zero mask surviving until they are revealed;
- the global reset clearing every piece of state;
- the window field ignoring the upper argument bits.

// File: rtl/cmd_status_unit.sv
module cmd_status_unit #(
  parameter int BUSY_CYC = 8,
  parameter int CNT_W    = $clog2(BUSY_CYC + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [15:0] cmd_data,
  input  logic [7:0]  ev_set,
  output logic [15:0] status,
  output logic        irq,
  output logic        busy,
  output logic [2:0]  win,
  output logic        rx_on,
  output logic        tx_on,
  output logic        stats_on,
  output logic        rx_rst_p,
  output logic        tx_rst_p,
  output logic        gbl_rst_p
);
  localparam logic [4:0] OP_GRST = 5'd0,  OP_WIN  = 5'd1,  OP_RXDIS = 5'd3,
                         OP_RXEN = 5'd4,  OP_RXRST = 5'd5, OP_TXEN = 5'd9,
                         OP_TXDIS = 5'd10, OP_TXRST = 5'd11, OP_REQ = 5'd12,
                         OP_ACK  = 5'd13, OP_IMASK = 5'd14, OP_RMASK = 5'd15,
                         OP_STEN = 5'd21, OP_STDIS = 5'd22;
  localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYC);

  logic [CNT_W-1:0] cnt;
  logic [7:1]       ev;
  logic [7:0]       imask, rmask;

  wire [4:0]  op     = cmd_data[15:11];
  wire [10:0] arg    = cmd_data[10:0];
  wire        take   = cmd_wr && !busy;
  wire        is_rst = take && (op == OP_GRST || op == OP_RXRST || op == OP_TXRST);
  wire [7:1]  set_v  = {ev_set[7], take && op == OP_REQ, ev_set[5:1]};
  wire [7:1]  clr_v  = (take && op == OP_ACK) ? arg[7:1] : 7'd0;
  wire        pend   = |(ev & imask[7:1]);

  assign busy   = cnt != '0;
  assign irq    = pend;
  assign status = {win, busy, 4'b0000, {ev, pend} & rmask};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      ev        <= '0;
      imask     <= '0;
      rmask     <= '0;
      win       <= '0;
      rx_on     <= 1'b0;
      tx_on     <= 1'b0;
      stats_on  <= 1'b0;
      rx_rst_p  <= 1'b0;
      tx_rst_p  <= 1'b0;
      gbl_rst_p <= 1'b0;
    end else begin
      rx_rst_p  <= take && op == OP_RXRST;
      tx_rst_p  <= take && op == OP_TXRST;
      gbl_rst_p <= take && op == OP_GRST;
      if (is_rst)    cnt <= BUSY_LOAD;
      else if (busy) cnt <= cnt - 1'b1;
      if (take && op == OP_GRST) begin
        ev       <= '0;
        imask    <= '0;
        rmask    <= '0;
        win      <= '0;
        rx_on    <= 1'b0;
        tx_on    <= 1'b0;
        stats_on <= 1'b0;
      end else begin
        ev <= (ev & ~clr_v) | set_v;
        if (take) begin
          case (op)
            OP_WIN:   win      <= arg[2:0];
            OP_RXEN:  rx_on    <= 1'b1;
            OP_RXDIS, OP_RXRST: rx_on <= 1'b0;
            OP_TXEN:  tx_on    <= 1'b1;
            OP_TXDIS, OP_TXRST: tx_on <= 1'b0;
            OP_STEN:  stats_on <= 1'b1;
            OP_STDIS: stats_on <= 1'b0;
            OP_IMASK: imask    <= arg[7:0];
            OP_RMASK: rmask    <= arg[7:0];
            default: ;
          endcase
        end
      end
    end
  end

  a_r8_busy_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> (win == $past(win)));
  a_r8_reset_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    is_rst |=> busy);
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == OP_ACK && ev_set == 8'd0) |=> ((ev & $past(arg[7:1])) == 7'd0));
  a_r6_req_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == OP_REQ) |=> ev[6]);
  a_r4_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (imask[7:1] != 7'd0));
  a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_rst_p, tx_rst_p, gbl_rst_p}));
endmodule

// File: tb/cmd_status_unit_tb_top.sv
module cmd_status_unit_tb_top;
  localparam int BUSY_CYC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_data = '0;
  logic [7:0]  ev_set = '0;
  logic [15:0] status;
  logic        irq, busy, rx_on, tx_on, stats_on, rx_rst_p, tx_rst_p, gbl_rst_p;
  logic [2:0]  win;

  cmd_status_unit #(.BUSY_CYC(BUSY_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .ev_set(ev_set),
    .status(status), .irq(irq), .busy(busy), .win(win), .rx_on(rx_on), .tx_on(tx_on),
    .stats_on(stats_on), .rx_rst_p(rx_rst_p), .tx_rst_p(tx_rst_p), .gbl_rst_p(gbl_rst_p));

  always #4 clk = ~clk;

  typedef struct {
    logic [15:0] st;
    logic [5:0]  fl;
    logic [2:0]  pul;
    string       tag;
  } item_t;
  item_t q[$];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [2:0] m_win = '0;
  logic [7:0] m_ev = '0, m_im = '0, m_rm = '0;
  logic       m_rx = 0, m_tx = 0, m_st = 0;
  logic [2:0] m_pul = '0;

  function automatic logic [15:0] exp_status(input logic b);
    logic pend;
    pend = |(m_ev[7:1] & m_im[7:1]);
    return {m_win, b, 4'b0000, ({m_ev[7:1], pend} & m_rm)};
  endfunction

  task automatic expect_now(input string tag, input logic b);
    item_t it;
    it.st  = exp_status(b);
    it.fl  = {|(m_ev[7:1] & m_im[7:1]), b, m_rx, m_tx, m_st, 1'b0};
    it.pul = m_pul;
    it.tag = tag;
    q.push_back(it);
  endtask

  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [5:0] got_fl;
      it = q.pop_front();
      got_fl = {irq, busy, rx_on, tx_on, stats_on, 1'b0};
      checks++;
      if (status !== it.st || got_fl !== it.fl ||
          {gbl_rst_p, tx_rst_p, rx_rst_p} !== it.pul) begin
        errors++;
        $display("FAIL %s: status=%h flags=%b pulses=%b expected status=%h flags=%b pulses=%b",
                 it.tag, status, got_fl, {gbl_rst_p, tx_rst_p, rx_rst_p},
                 it.st, it.fl, it.pul);
      end
    end
  end

  task automatic cmd(input logic [4:0] o, input logic [10:0] a, input bit acc,
                     input logic [7:0] e);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_data = {o, a}; ev_set = e;
    @(negedge clk);
    cmd_wr = 1'b0; ev_set = '0;
    m_pul = '0;
    if (acc) begin
      case (o)
        5'd0: begin m_win = 0; m_ev = 0; m_im = 0; m_rm = 0;
                    m_rx = 0; m_tx = 0; m_st = 0; m_pul = 3'b100; end
        5'd1: m_win = a[2:0];
        5'd3: m_rx = 0;
        5'd4: m_rx = 1;
        5'd5: begin m_rx = 0; m_pul = 3'b001; end
        5'd9: m_tx = 1;
        5'd10: m_tx = 0;
        5'd11: begin m_tx = 0; m_pul = 3'b010; end
        5'd12: m_ev[6] = 1;
        5'd13: m_ev = m_ev & ~{a[7:1], 1'b0};
        5'd14: m_im = a[7:0];
        5'd15: m_rm = a[7:0];
        5'd21: m_st = 1;
        5'd22: m_st = 0;
        default: ;
      endcase
    end
    if (!(acc && o == 5'd0)) m_ev = m_ev | {e[7], 1'b0, e[5:1], 1'b0};
  endtask

  task automatic raise(input logic [7:0] e);
    @(negedge clk);
    ev_set = e;
    @(negedge clk);
    ev_set = '0;
    m_pul = '0;
    m_ev = m_ev | {e[7], 1'b0, e[5:1], 1'b0};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    m_pul = '0;
  endtask

  initial begin
    #5000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    expect_now("R1 reset state", 0);

    cmd(5'd1, 11'h7FD, 1, 0);           expect_now("R2 window from low arg bits", 0);
    raise(8'hFF);                       expect_now("R5 events hidden by zero read mask", 0);
    cmd(5'd15, 11'h0FF, 1, 0);          expect_now("R5 events revealed, R6 bits 6/0 ignored", 0);
    cmd(5'd14, 11'h004, 1, 0);          expect_now("R4 irq from masked event", 0);
    cmd(5'd13, 11'h00C, 1, 0);          expect_now("R3 selective acknowledge", 0);
    cmd(5'd13, 11'h001, 1, 0);          expect_now("R3 ack bit 0 no effect", 0);
    cmd(5'd12, 11'h000, 1, 0);          expect_now("R6 request sets bit 6", 0);
    cmd(5'd14, 11'h040, 1, 0);          expect_now("R4 irq on requested bit", 0);
    cmd(5'd15, 11'h00F, 1, 0);          expect_now("R5 partial read mask", 0);
    cmd(5'd13, 11'h0F0, 1, 8'h10);      expect_now("R10 set wins over ack", 0);
    cmd(5'd15, 11'h0FF, 1, 0);          expect_now("R10 bit 4 still latched", 0);
    cmd(5'd4, 11'h000, 1, 0);           expect_now("R7 rx enable", 0);
    cmd(5'd9, 11'h000, 1, 0);           expect_now("R7 tx enable", 0);
    cmd(5'd21, 11'h000, 1, 0);          expect_now("R7 stats enable", 0);
    cmd(5'd22, 11'h000, 1, 0);          expect_now("R7 stats disable", 0);
    cmd(5'd10, 11'h000, 1, 0);          expect_now("R7 tx disable", 0);
    cmd(5'd9, 11'h000, 1, 0);           expect_now("R7 tx enable again", 0);

    cmd(5'd11, 11'h000, 1, 0);          expect_now("R9 tx reset pulse, R8 busy", 1);
    cmd(5'd1, 11'h002, 0, 0);           expect_now("R8 write ignored while busy", 1);
    idle(5);                            expect_now("R8 busy on last cycle", 1);
    idle(1);                            expect_now("R8 busy released", 0);

    cmd(5'd3, 11'h000, 1, 0);           expect_now("R7 rx disable", 0);
    cmd(5'd4, 11'h000, 1, 0);           expect_now("R7 rx enable again", 0);
    cmd(5'd5, 11'h000, 1, 0);           expect_now("R9 rx reset pulse", 1);
    idle(BUSY_CYC);                     expect_now("R8 busy released after rx reset", 0);

    cmd(5'd0, 11'h000, 1, 0);           expect_now("R9 global reset clears state", 1);
    idle(BUSY_CYC - 1);                 expect_now("R8 busy held full window", 1);
    idle(1);                            expect_now("R8 busy released after global reset", 0);

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule